// File: doc/BRIEF.md
# Three-Wire Serial Memory Instruction Front End

This block is the device side of a three-wire serial memory. It watches a chip select, a serial clock and a serial data line. These three lines are synchronized into a faster system clock, and the block then picks out the start bit and shifts in a two-bit opcode and an address. It decodes all seven instructions and answers reads on a serial output that can be tri-stated. A width select chooses between byte-wide and 16-bit-wide organization of the same storage. A small register array stands in for the memory cells.

The block also keeps the write-enable latch. Write-type instructions are not carried out here. When select falls after such an instruction, the block raises a one-cycle request that holds the operation, address, data, width and the number of clock pulses counted since the start bit. The external program timer and the length checker use that count. Those blocks answer with an apply pulse, and only then is the array changed.

Top module: `mw_serial_front`

## Requirements
- R1: An instruction is accepted only if select rises while the serial clock is low. If select rises while the clock is high, everything up to the next fall of select is ignored: no output is driven and no request is raised.
- R2: Zeros sampled on the data line before the first 1 are ignored. The first 1 is the start bit.
- R3: After the start bit come two opcode bits, decoded as 10 read, 01 write and 11 erase. For opcode 00, the two most significant address bits choose the command: 11 enable writes, 00 disable writes, 10 erase all, 01 write all. The other address bits are don't-care.
- R4: The address is AW bits long in 16-bit mode and AW+1 bits long in byte mode, sent MSB first. Word a is stored as byte 2a (upper half) and byte 2a+1 (lower half).
- R5: A read first drives a single 0 on the output, in the clock period after the last address bit. The addressed word then follows MSB first, one bit after each rising edge of the serial clock.
- R6: While select stays high, a read continues into the next word with no extra 0 bit. After the highest address it wraps to address 0.
- R7: The output enable is low after reset and after select falls. It is high only while read data is being driven.
- R8: The write-enable latch is clear after reset. The enable command sets it and the disable command clears it. A write-type instruction issued while the latch is clear raises no request. Reads work whatever the latch state.
- R9: A request is raised for one cycle when select falls after a complete write, erase, erase-all or write-all instruction. The request carries the kind (0 write, 1 erase, 2 erase all, 3 write all), the address, the data (in the low byte in byte mode), the width and the count of clock pulses from the start bit up to the fall of select. An instruction that stops before its last bit raises no request.
- R10: An apply pulse carries out the latest request. Write stores the data. Erase sets the addressed location to all ones. Erase all sets every byte to FFh. Write all stores the data in every location.
- R11: After reset every byte of the array holds FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mw_cs | input | 1 | Chip select, active high |
| mw_sck | input | 1 | Serial clock |
| mw_di | input | 1 | Serial data in |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| mw_do | output | 1 | Serial data out |
| mw_do_en | output | 1 | Output enable for mw_do (low means high impedance) |
| prog_req | output | 1 | One-cycle program request |
| prog_kind | output | 2 | Request kind |
| prog_addr | output | AW+1 | Request address |
| prog_data | output | 16 | Request data |
| prog_wide | output | 1 | Width of the request |
| prog_pulses | output | 6 | Clock pulses counted from the start bit |
| prog_apply | input | 1 | Carries out the latest request |

## Verification
The bench uses the default AW of 6, which gives 64 words or 128 bytes. At that size it can write a distinct value into every word and read the whole array back in one select period. That stream runs past the top address, so the wrap is exercised in both widths. The small size also lets the bench check that the byte and word views of the same cells agree, and that the pulse counts match the arithmetic for every instruction format, including one with an extra clock.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_HUNT, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_END
  } phase_t;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_ERASE = 2'd1;
  localparam logic [1:0] KIND_ERAL  = 2'd2;
  localparam logic [1:0] KIND_WRAL  = 2'd3;

  // number of address bits for the selected organization
  function automatic int addr_len(input int aw, input logic wide);
    return wide ? aw : aw + 1;
  endfunction

  // index of the most significant data bit
  function automatic logic [3:0] word_top(input logic wide);
    return wide ? 4'd15 : 4'd7;
  endfunction
endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic s0, s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s0 <= 1'b0;
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s0 <= raw[g];
        s1 <= s0;
        s2 <= s1;
      end
    end
    assign lvl[g]  = s1;
    assign rise[g] = s1 & ~s2;
    assign fall[g] = ~s1 & s2;
  end
endmodule

// File: rtl/mw_byte_array.sv
module mw_byte_array
  import mw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   rd_addr,
  input  logic          rd_wide,
  output logic [15:0]   rd_word,
  input  logic          wr_go,
  input  logic [1:0]    wr_kind,
  input  logic [AW:0]   wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          wr_wide
);
  localparam int AW1 = AW + 1;
  localparam int NB  = 1 << AW1;

  logic [7:0] cells [NB];

  function automatic logic hit(input int i);
    if (wr_kind == KIND_ERAL || wr_kind == KIND_WRAL) return 1'b1;
    if (wr_wide) return wr_addr[AW-1:0] == AW'(i >> 1);
    return wr_addr == AW1'(i);
  endfunction

  function automatic logic [7:0] lane_val(input int i);
    if (wr_kind == KIND_ERASE || wr_kind == KIND_ERAL) return 8'hFF;
    if (wr_wide && (i % 2 == 0)) return wr_data[15:8];
    return wr_data[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) cells[i] <= 8'hFF;
    end else if (wr_go) begin
      for (int i = 0; i < NB; i++)
        if (hit(i)) cells[i] <= lane_val(i);
    end
  end

  always_comb begin
    if (rd_wide) rd_word = {cells[{rd_addr[AW-1:0], 1'b0}], cells[{rd_addr[AW-1:0], 1'b1}]};
    else         rd_word = {8'h00, cells[rd_addr]};
  end

  a_r10_eral_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_kind == KIND_ERAL) |=> (cells[0] == 8'hFF && cells[NB-1] == 8'hFF));
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sel_rise,
  input  logic          sel_fall,
  input  logic          clk_hi,
  input  logic          clk_rise,
  input  logic          din,
  input  logic          org_wide,
  input  logic [15:0]   rd_word,
  output logic [AW:0]   rd_addr,
  output logic          rd_wide,
  output logic          dout,
  output logic          dout_en,
  output logic          prog_req,
  output logic [1:0]    prog_kind,
  output logic [AW:0]   prog_addr,
  output logic [15:0]   prog_data,
  output logic          prog_wide,
  output logic [PW-1:0] prog_pulses
);
  localparam int CW = 5;

  phase_t        phase;
  logic [1:0]    opc, kind_q;
  logic [AW:0]   asr, addr_q;
  logic [15:0]   dsr;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulses;
  logic [3:0]    idx;
  logic          wide_q, armed, wel;

  function automatic logic [AW:0] next_addr(input logic [AW:0] a, input logic w);
    logic [AW:0] n;
    n = a + 1'b1;
    if (w) n[AW] = 1'b0;
    return n;
  endfunction

  logic [AW:0]   a_nxt, addr_val;
  logic [1:0]    ext;
  logic [3:0]    wtop;
  logic          last_adr, last_dat;
  logic          start_evt, decode_evt, req_evt;

  always_comb begin
    a_nxt     = {asr[AW-1:0], din};
    addr_val  = wide_q ? {1'b0, a_nxt[AW-1:0]} : a_nxt;
    ext       = wide_q ? a_nxt[AW-1:AW-2] : a_nxt[AW:AW-1];
    wtop      = word_top(wide_q);
    last_adr  = cnt == CW'(addr_len(AW, wide_q) - 1);
    last_dat  = cnt == CW'(wtop);
    start_evt = phase == ST_HUNT && clk_rise && din;
    decode_evt = phase == ST_ADR && clk_rise && last_adr;
    req_evt   = sel_fall && armed && wel && phase == ST_END;
  end

  assign rd_wide = wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_OFF; opc <= '0; kind_q <= '0; asr <= '0; addr_q <= '0;
      dsr <= '0; cnt <= '0; pulses <= '0; idx <= '0; wide_q <= 1'b0;
      armed <= 1'b0; wel <= 1'b0; rd_addr <= '0; dout <= 1'b0; dout_en <= 1'b0;
      prog_req <= 1'b0; prog_kind <= '0; prog_addr <= '0; prog_data <= '0;
      prog_wide <= 1'b0; prog_pulses <= '0;
    end else begin
      prog_req <= 1'b0;
      if (sel_fall) begin
        phase <= ST_OFF; dout_en <= 1'b0; dout <= 1'b0; armed <= 1'b0;
        if (req_evt) begin
          prog_req <= 1'b1; prog_kind <= kind_q; prog_addr <= addr_q;
          prog_data <= dsr; prog_wide <= wide_q; prog_pulses <= pulses;
        end
      end else if (sel_rise) begin
        phase <= clk_hi ? ST_END : ST_HUNT;
        armed <= 1'b0;
      end else if (clk_rise) begin
        if (phase != ST_OFF && phase != ST_HUNT && pulses != '1) pulses <= pulses + 1'b1;
        case (phase)
          ST_HUNT: if (start_evt) begin
            phase <= ST_OPC; cnt <= '0; pulses <= PW'(1); wide_q <= org_wide; dsr <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], din};
            if (cnt == CW'(1)) begin phase <= ST_ADR; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_ADR: begin
            asr <= a_nxt;
            cnt <= cnt + 1'b1;
            if (decode_evt) begin
              cnt <= '0;
              addr_q <= addr_val;
              case (opc)
                2'b10: begin
                  phase <= ST_RD; rd_addr <= addr_val; idx <= wtop;
                  dout <= 1'b0; dout_en <= 1'b1;
                end
                2'b01: begin phase <= ST_DAT; kind_q <= KIND_WRITE; end
                2'b11: begin phase <= ST_END; kind_q <= KIND_ERASE; armed <= 1'b1; end
                default: case (ext)
                  2'b11: begin phase <= ST_END; wel <= 1'b1; end
                  2'b00: begin phase <= ST_END; wel <= 1'b0; end
                  2'b10: begin phase <= ST_END; kind_q <= KIND_ERAL; armed <= 1'b1; end
                  default: begin phase <= ST_DAT; kind_q <= KIND_WRAL; end
                endcase
              endcase
            end
          end
          ST_DAT: begin
            dsr <= {dsr[14:0], din};
            cnt <= cnt + 1'b1;
            if (last_dat) begin phase <= ST_END; armed <= 1'b1; end
          end
          ST_RD: begin
            dout <= rd_word[idx];
            if (idx == 4'd0) begin
              rd_addr <= next_addr(rd_addr, wide_q);
              idx <= wtop;
            end else idx <= idx - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r7_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (sel || sel_fall));
  a_r5_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> !dout);
  a_r9_request_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  a_r8_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> wel);
  a_r2_zero_keeps_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_HUNT && clk_rise && !din && !sel_fall) |=> phase == ST_HUNT);
endmodule

// File: rtl/mw_serial_front.sv
module mw_serial_front
  import mw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mw_cs,
  input  logic          mw_sck,
  input  logic          mw_di,
  input  logic          org_wide,
  output logic          mw_do,
  output logic          mw_do_en,
  output logic          prog_req,
  output logic [1:0]    prog_kind,
  output logic [AW:0]   prog_addr,
  output logic [15:0]   prog_data,
  output logic          prog_wide,
  output logic [5:0]    prog_pulses,
  input  logic          prog_apply
);
  localparam int LANES = 3;

  logic [LANES-1:0] lvl, rise, fall;
  logic [AW:0]      rd_addr;
  logic             rd_wide;
  logic [15:0]      rd_word;

  mw_edge_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({mw_cs, mw_sck, mw_di}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  mw_decoder #(.AW(AW), .PW(6)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .sel(lvl[2]), .sel_rise(rise[2]), .sel_fall(fall[2]),
    .clk_hi(lvl[1]), .clk_rise(rise[1]), .din(lvl[0]),
    .org_wide(org_wide), .rd_word(rd_word),
    .rd_addr(rd_addr), .rd_wide(rd_wide),
    .dout(mw_do), .dout_en(mw_do_en),
    .prog_req(prog_req), .prog_kind(prog_kind), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_wide(prog_wide), .prog_pulses(prog_pulses)
  );

  mw_byte_array #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_word(rd_word),
    .wr_go(prog_apply), .wr_kind(prog_kind), .wr_addr(prog_addr),
    .wr_data(prog_data), .wr_wide(prog_wide)
  );
endmodule

// File: tb/mw_serial_front_test.sv
module mw_serial_front_test;
  localparam int AW = 6;
  localparam int NB = 1 << (AW + 1);

  logic clk = 0, rst_n = 0, mw_cs = 0, mw_sck = 0, mw_di = 0, org_wide = 1, prog_apply = 0;
  logic mw_do, mw_do_en, prog_req, prog_wide;
  logic [1:0] prog_kind;
  logic [AW:0] prog_addr;
  logic [15:0] prog_data;
  logic [5:0] prog_pulses;

  mw_serial_front #(.AW(AW)) uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_req = 0;
  bit done = 0;
  logic [7:0] mdl [NB];
  logic [1:0] c_kind; logic [AW:0] c_addr; logic [15:0] c_data; logic c_wide; logic [5:0] c_pulses;

  always @(negedge clk) if (prog_req) begin
    n_req++; c_kind = prog_kind; c_addr = prog_addr; c_data = prog_data;
    c_wide = prog_wide; c_pulses = prog_pulses;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic sbit(input logic b, output logic q);
    mw_di = b; tick(4); mw_sck = 1; tick(4); q = mw_do; mw_sck = 0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) sbit(v[i], q);
  endtask

  task automatic open_sel(); mw_sck = 0; tick(2); mw_cs = 1; tick(4); endtask
  task automatic close_sel(); mw_sck = 0; mw_cs = 0; tick(6); endtask

  function automatic int alen(input bit w); return w ? AW : AW + 1; endfunction

  function automatic logic [15:0] mword(input bit w, input int a);
    return w ? {mdl[2*a], mdl[2*a+1]} : {8'h00, mdl[a]};
  endfunction

  // expected array effect of an applied request
  task automatic mdl_apply(input int kind, input bit w, input int a, input logic [15:0] d);
    for (int i = 0; i < NB; i++) begin
      bit h = (kind >= 2) || (w ? (i / 2 == a) : (i == a));
      logic [7:0] v = (kind == 1 || kind == 2) ? 8'hFF : ((w && i % 2 == 0) ? d[15:8] : d[7:0]);
      if (h) mdl[i] = v;
    end
  endtask

  task automatic exec(input bit w, input logic [1:0] op, input int a,
                      input logic [15:0] d, input int dbits, input int extra);
    org_wide = w; open_sel();
    send({30'd0, 1'b1, op[1]}, 2); send({31'd0, op[0]}, 1);
    send(32'(a), alen(w));
    if (dbits > 0) send({16'd0, d} >> ((w ? 16 : 8) - dbits), dbits);
    if (extra > 0) send(0, extra);
    close_sel();
  endtask

  task automatic do_apply(); prog_apply = 1; tick(1); prog_apply = 0; tick(2); endtask

  task automatic req_chk(input string tag, input int r0, input int k, input int a,
                         input logic [15:0] d, input bit w, input int p);
    chk({tag, " count"}, n_req, r0 + 1);
    chk({tag, " kind"}, c_kind, k);
    chk({tag, " addr"}, c_addr, a);
    if (k == 0 || k == 3) chk({tag, " data"}, c_data, w ? d : {8'h00, d[7:0]});
    chk({tag, " wide"}, c_wide, w);
    chk({tag, " pulses"}, c_pulses, p);
  endtask

  task automatic rd_check(input bit w, input int a, input int n, input int lead, input string tag);
    logic q; logic [15:0] got; int depth = w ? NB / 2 : NB;
    org_wide = w; open_sel();
    if (lead > 0) send(0, lead);
    send(3'b110, 3);
    send(32'(a >> 1), alen(w) - 1);
    sbit(1'(a & 1), q);
    chk({tag, " R5 dummy"}, q, 0);
    chk({tag, " R7 enable"}, mw_do_en, 1);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < (w ? 16 : 8); b++) begin sbit(0, q); got = {got[14:0], q}; end
      chk({tag, " R6 word"}, got, mword(w, (a + k) % depth));
    end
    close_sel();
    chk({tag, " R7 released"}, mw_do_en, 0);
  endtask

  initial begin
    int r0; logic q; bit seen;
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    tick(5); rst_n = 1; tick(3);
    chk("R7 reset enable", mw_do_en, 0);
    chk("R9 reset req", prog_req, 0);
    rd_check(1, 0, 2, 0, "R11 reset content");

    r0 = n_req; exec(1, 2'b01, 5, 16'h1234, 16, 0);
    chk("R8 write while disabled", n_req, r0);
    r0 = n_req; exec(1, 2'b00, 3 << (AW - 2), 0, 0, 0);
    chk("R3 enable gives no request", n_req, r0);

    r0 = n_req; exec(1, 2'b01, 5, 16'h1234, 16, 0);
    req_chk("R9 word write", r0, 0, 5, 16'h1234, 1, 25);
    do_apply(); mdl_apply(0, 1, 5, 16'h1234);
    rd_check(1, 5, 1, 0, "R10 word write");

    r0 = n_req; exec(0, 2'b01, 11, 16'h00A5, 8, 0);
    req_chk("R9 byte write", r0, 0, 11, 16'h00A5, 0, 18);
    do_apply(); mdl_apply(0, 0, 11, 16'h00A5);
    rd_check(1, 5, 1, 0, "R4 word view");
    rd_check(0, 10, 2, 0, "R4 byte view");

    r0 = n_req; exec(1, 2'b11, 5, 0, 0, 0);
    req_chk("R9 erase", r0, 1, 5, 0, 1, 9);
    do_apply(); mdl_apply(1, 1, 5, 0);
    rd_check(1, 4, 2, 0, "R10 erase");

    for (int a = 0; a < NB / 2; a++) begin
      logic [15:0] v = 16'(a * 16'h0101) ^ 16'hC35A;
      exec(1, 2'b01, a, v, 16, 0); do_apply(); mdl_apply(0, 1, a, v);
    end
    rd_check(1, 0, NB / 2 + 1, 0, "R6 word sweep wrap");
    rd_check(0, NB - 8, 16, 0, "R6 byte wrap");

    // R1: select raised while the clock is high
    r0 = n_req; seen = 0;
    mw_sck = 1; tick(2); mw_cs = 1; tick(4); mw_sck = 0; tick(4);
    send(3'b110, 3);
    for (int i = 0; i < AW + 16; i++) begin sbit(0, q); if (mw_do_en) seen = 1; end
    send({1'b1, 2'b01, 6'd7, 16'hBEEF}, 25);
    close_sel();
    chk("R1 no drive", seen, 0);
    chk("R1 no request", n_req, r0);
    rd_check(1, 7, 1, 0, "R1 content kept");

    rd_check(1, 9, 2, 3, "R2 leading zeros");

    r0 = n_req; exec(1, 2'b00, 1 << (AW - 2), 16'h5A5A, 16, 0);
    req_chk("R9 write all", r0, 3, 1 << (AW - 2), 16'h5A5A, 1, 25);
    do_apply(); mdl_apply(3, 1, 0, 16'h5A5A);
    rd_check(1, NB / 2 - 2, 4, 0, "R10 write all");

    r0 = n_req; exec(0, 2'b00, 2 << (AW - 1), 0, 0, 0);
    req_chk("R9 erase all", r0, 2, 2 << (AW - 1), 0, 0, 10);
    do_apply(); mdl_apply(2, 0, 0, 0);
    rd_check(0, 0, 3, 0, "R10 erase all");

    r0 = n_req; exec(1, 2'b01, 3, 16'h0F0F, 16, 1);
    req_chk("R9 extra pulse count", r0, 0, 3, 16'h0F0F, 1, 26);

    r0 = n_req; exec(1, 2'b01, 3, 16'h0F0F, 10, 0);
    chk("R9 short instruction", n_req, r0);

    exec(1, 2'b00, 0, 0, 0, 0);
    r0 = n_req; exec(1, 2'b01, 3, 16'h0F0F, 16, 0);
    chk("R8 disabled after disable", n_req, r0);
    rd_check(1, 3, 1, 0, "R8 read while disabled");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule